// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block handles collisions for the transmit side of a half-duplex Ethernet MAC. The transmitter reports which stage of a frame it is sending (preamble with start delimiter, or payload) and how many payload bits have gone out. The block watches the collision-detect line and decides when the jam pattern has to be sent. It also counts the attempts made on the current frame and asks an external generator for a random backoff delay before each retry.

When a frame finally succeeds or is given up, the block reports how it ended. It raises a one-cycle completion strobe together with status flags for one retry, several retries, or retry failure. A frame that is given up also gets a one-cycle request to flush it from the transmit FIFO. A retry-disable input turns the first collision into a failure. The backoff generator and the line coder sit outside this block.

Top module: `coll_retry_ctrl`

## Requirements
- R1: After reset, every output is low and the block waits for `frame_start`.
- R2: A collision seen while `tx_stage` is 2'b01 (preamble) does not start the jam. The jam begins one cycle after the first clock edge at which `tx_stage` is 2'b10 (payload).
- R3: A collision seen while `tx_stage` is 2'b10 and `bit_cnt` is below 512 starts the jam at once. `jam_en` and `tx_abort` are both high in the cycle after the clock edge that sampled the collision.
- R4: `jam_en` stays high for exactly 32 consecutive cycles, during which the transmitter sends 32 zero bits. `tx_abort` is a one-cycle pulse in the first of those cycles.
- R5: A collision has no effect when `bit_cnt` is 512 or more, or when no attempt is active: no jam starts and the frame can still complete normally.
- R6: When a jam ends with retries allowed and fewer than 16 attempts made, `backoff_req` pulses for one cycle in the cycle right after the last jam cycle. `backoff_attempt` then carries the number of collisions so far (1 to 15). The next attempt starts on the clock edge that samples `backoff_done`.
- R7: When `tx_done` is sampled in the payload stage without a collision, `frame_done` pulses the next cycle. At that point `st_one` is set if exactly one retry was made, and `st_more` is set if more than one was made.
- R8: If the 16th attempt also collides, the jam is followed by a single cycle with `frame_done` and `fifo_flush` high. In that cycle `st_fail` is set and `st_one` and `st_more` are clear, and no backoff is requested.
- R9: With `retry_dis` high, the first collision ends the frame after its jam. The block gives `frame_done`, `fifo_flush` and `st_fail` only, and no backoff request.
- R10: The status flags clear one cycle after `frame_start` is sampled, and otherwise hold their value until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one transmit bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin a new frame (sampled only when idle) |
| tx_stage | input | 2 | 00 idle, 01 preamble/delimiter, 10 payload |
| bit_cnt | input | BIT_W | Payload bits sent in this attempt |
| col_det | input | 1 | Collision detected |
| tx_done | input | 1 | Last payload bit sent |
| retry_dis | input | 1 | Abandon the frame on its first collision |
| backoff_done | input | 1 | Backoff delay has elapsed |
| jam_en | output | 1 | Send jam bits |
| tx_abort | output | 1 | Stop payload, jam starting |
| backoff_req | output | 1 | Request a backoff delay |
| backoff_attempt | output | $clog2(MAX_ATT+1) | Collision count for the backoff |
| frame_done | output | 1 | Frame finished, status valid |
| fifo_flush | output | 1 | Discard the frame from the FIFO |
| st_one | output | 1 | Exactly one retry was made |
| st_more | output | 1 | More than one retry was made |
| st_fail | output | 1 | Retries exhausted or disabled |

## Verification
Every result appears one cycle after the edge that sampled its cause. `tx_abort` and `jam_en` rise one cycle after a payload-stage collision, or one cycle after the first payload edge when a preamble collision is pending. `backoff_req`, or the `frame_done`/`fifo_flush` pair, follows the 32nd jam cycle with no gap. The flags change with `frame_done`, and clear one cycle after `frame_start`. The bench drives its inputs on falling edges and advances a behavioural model on rising edges. It compares every output on each falling edge, and its directed checks sample on the falling edge that sits exactly one register stage after the stimulus.

// File: rtl/jrc_pkg.sv
package jrc_pkg;

  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_ACTIVE = 2'd1,
    CS_JAM    = 2'd2,
    CS_WAIT   = 2'd3
  } ctl_state_t;

  localparam logic [1:0] STG_IDLE = 2'b00;
  localparam logic [1:0] STG_PRE  = 2'b01;
  localparam logic [1:0] STG_DATA = 2'b10;

  // retries made = attempts - 1
  function automatic logic flag_one(input int unsigned attempts);
    return attempts == 2;
  endfunction

  function automatic logic flag_more(input int unsigned attempts);
    return attempts > 2;
  endfunction

endpackage

// File: rtl/jrc_jam_timer.sv
module jrc_jam_timer #(
  parameter int JAM_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == CW'(JAM_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jrc_attempt_ctr.sv
module jrc_attempt_ctr #(
  parameter int MAX_ATT = 16,
  parameter int ATT_W   = $clog2(MAX_ATT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ATT_W-1:0] count,
  output logic             at_limit
);
  assign at_limit = (count == ATT_W'(MAX_ATT));

  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (clr)               count <= ATT_W'(1);
    else if (inc && !at_limit)  count <= count + 1'b1;
  end
endmodule

// File: rtl/jrc_status.sv
module jrc_status #(
  parameter int ATT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ok,
  input  logic             give_up,
  input  logic [ATT_W-1:0] attempts,
  output logic             st_one,
  output logic             st_more,
  output logic             st_fail
);
  import jrc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st_one  <= 1'b0;
      st_more <= 1'b0;
      st_fail <= 1'b0;
    end else if (give_up) begin
      st_one  <= 1'b0;
      st_more <= 1'b0;
      st_fail <= 1'b1;
    end else if (ok) begin
      st_one  <= flag_one(int'(attempts));
      st_more <= flag_more(int'(attempts));
      st_fail <= 1'b0;
    end
  end
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl #(
  parameter int BIT_W     = 16,
  parameter int SLOT_BITS = 512,
  parameter int JAM_BITS  = 32,
  parameter int MAX_ATT   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_start,
  input  logic [1:0]                     tx_stage,
  input  logic [BIT_W-1:0]               bit_cnt,
  input  logic                           col_det,
  input  logic                           tx_done,
  input  logic                           retry_dis,
  input  logic                           backoff_done,
  output logic                           jam_en,
  output logic                           tx_abort,
  output logic                           backoff_req,
  output logic [$clog2(MAX_ATT+1)-1:0]   backoff_attempt,
  output logic                           frame_done,
  output logic                           fifo_flush,
  output logic                           st_one,
  output logic                           st_more,
  output logic                           st_fail
);
  import jrc_pkg::*;

  localparam int ATT_W = $clog2(MAX_ATT + 1);

  ctl_state_t       st;
  logic             pend;
  logic [ATT_W-1:0] att;
  logic             at_limit;
  logic             jam_busy, jam_last;

  // named internal events
  logic in_pre, in_data, in_slot;
  logic ev_new, ev_coll_pre, ev_start_jam, ev_success;
  logic ev_jam_end, ev_give_up, ev_retry, ev_resume;

  assign in_pre  = (tx_stage == STG_PRE);
  assign in_data = (tx_stage == STG_DATA);
  assign in_slot = (bit_cnt < BIT_W'(SLOT_BITS));

  assign ev_new       = (st == CS_IDLE) && frame_start;
  assign ev_coll_pre  = (st == CS_ACTIVE) && in_pre && col_det;
  assign ev_start_jam = (st == CS_ACTIVE) && in_data && (pend || (col_det && in_slot));
  assign ev_success   = (st == CS_ACTIVE) && in_data && tx_done && !ev_start_jam;
  assign ev_jam_end   = (st == CS_JAM) && jam_last;
  assign ev_give_up   = ev_jam_end && (retry_dis || at_limit);
  assign ev_retry     = ev_jam_end && !ev_give_up;
  assign ev_resume    = (st == CS_WAIT) && backoff_done;

  jrc_jam_timer #(.JAM_BITS(JAM_BITS)) u_jam (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_start_jam),
    .busy  (jam_busy),
    .last  (jam_last)
  );

  jrc_attempt_ctr #(.MAX_ATT(MAX_ATT), .ATT_W(ATT_W)) u_att (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_new),
    .inc      (ev_resume),
    .count    (att),
    .at_limit (at_limit)
  );

  jrc_status #(.ATT_W(ATT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_new),
    .ok       (ev_success),
    .give_up  (ev_give_up),
    .attempts (att),
    .st_one   (st_one),
    .st_more  (st_more),
    .st_fail  (st_fail)
  );

  assign jam_en = jam_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= CS_IDLE;
      pend <= 1'b0;
    end else begin
      unique case (st)
        CS_IDLE: if (ev_new) begin
          st   <= CS_ACTIVE;
          pend <= 1'b0;
        end
        CS_ACTIVE: begin
          if (ev_coll_pre) pend <= 1'b1;
          if (ev_start_jam)    st <= CS_JAM;
          else if (ev_success) st <= CS_IDLE;
        end
        CS_JAM: begin
          if (ev_give_up)    st <= CS_IDLE;
          else if (ev_retry) st <= CS_WAIT;
        end
        CS_WAIT: if (ev_resume) begin
          st   <= CS_ACTIVE;
          pend <= 1'b0;
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_abort        <= 1'b0;
      backoff_req     <= 1'b0;
      backoff_attempt <= '0;
      frame_done      <= 1'b0;
      fifo_flush      <= 1'b0;
    end else begin
      tx_abort    <= ev_start_jam;
      backoff_req <= ev_retry;
      frame_done  <= ev_success || ev_give_up;
      fifo_flush  <= ev_give_up;
      if (ev_retry) backoff_attempt <= att;
    end
  end
endmodule

// File: rtl/jrc_chk.sv
module jrc_chk #(
  parameter int JAM_BITS = 32,
  parameter int MAX_ATT  = 16,
  parameter int ATT_W    = $clog2(MAX_ATT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             jam_en,
  input logic             tx_abort,
  input logic             backoff_req,
  input logic [ATT_W-1:0] backoff_attempt,
  input logic             frame_done,
  input logic             fifo_flush,
  input logic             st_one,
  input logic             st_more,
  input logic             st_fail
);
  localparam int RW = $clog2(JAM_BITS + 2);

  logic [RW-1:0] jrun;

  always_ff @(posedge clk) begin
    if (!rst_n)      jrun <= '0;
    else if (jam_en) jrun <= jrun + 1'b1;
    else             jrun <= '0;
  end

  // R4
  jam_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_en) |-> (jrun == RW'(JAM_BITS)));

  // R4
  jam_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jrun <= RW'(JAM_BITS));

  // R3
  jam_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_en) |-> tx_abort);

  // R4
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);

  // R6
  backoff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_req |-> (backoff_attempt >= ATT_W'(1) && backoff_attempt < ATT_W'(MAX_ATT)));

  // R6
  backoff_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_req |-> ($past(jam_en) && !jam_en));

  // R7
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_one, st_more, st_fail}));

  // R8
  flush_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (frame_done && st_fail && !st_one && !st_more));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind coll_retry_ctrl jrc_chk #(.JAM_BITS(JAM_BITS), .MAX_ATT(MAX_ATT)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .jam_en          (jam_en),
  .tx_abort        (tx_abort),
  .backoff_req     (backoff_req),
  .backoff_attempt (backoff_attempt),
  .frame_done      (frame_done),
  .fifo_flush      (fifo_flush),
  .st_one          (st_one),
  .st_more         (st_more),
  .st_fail         (st_fail)
);

// File: tb/tb_coll_retry_ctrl.sv
module tb_coll_retry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, col_det = 0, tx_done = 0, retry_dis = 0, backoff_done = 0;
  logic [1:0] tx_stage = 2'b00;
  logic [BIT_W-1:0] bit_cnt = '0;
  logic jam_en, tx_abort, backoff_req, frame_done, fifo_flush, st_one, st_more, st_fail;
  logic [4:0] backoff_attempt;

  int checks = 0, errors = 0, cycles = 0;

  coll_retry_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_st = 0, m_att = 0, m_jc = 0;
  bit m_pend = 0;
  bit e_abort = 0, e_req = 0, e_done = 0, e_flush = 0, e_one = 0, e_more = 0, e_fail = 0;
  int e_ratt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_att = 0; m_pend = 0;
      e_abort = 0; e_req = 0; e_done = 0; e_flush = 0;
      e_one = 0; e_more = 0; e_fail = 0;
    end else begin
      e_abort = 0; e_req = 0; e_done = 0; e_flush = 0;
      case (m_st)
        0: if (frame_start) begin
          m_att = 1; m_pend = 0; e_one = 0; e_more = 0; e_fail = 0; m_st = 1;
        end
        1: begin
          if (tx_stage == 2'b01 && col_det) m_pend = 1;
          if (tx_stage == 2'b10 && (m_pend || (col_det && bit_cnt < 512))) begin
            m_st = 2; m_jc = 0; e_abort = 1;
          end else if (tx_stage == 2'b10 && tx_done) begin
            e_done = 1; e_one = (m_att == 2); e_more = (m_att > 2); e_fail = 0; m_st = 0;
          end
        end
        2: begin
          m_jc++;
          if (m_jc == 32) begin
            if (retry_dis || m_att == 16) begin
              e_done = 1; e_flush = 1; e_fail = 1; e_one = 0; e_more = 0; m_st = 0;
            end else begin
              e_req = 1; e_ratt = m_att; m_st = 3;
            end
          end
        end
        default: if (backoff_done) begin
          m_att++; m_pend = 0; m_st = 1;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(jam_en == (m_st == 2), "R4 jam_en", jam_en, m_st == 2);
      chk(tx_abort == e_abort, "R3 tx_abort", tx_abort, e_abort);
      chk(backoff_req == e_req, "R6 backoff_req", backoff_req, e_req);
      if (e_req) chk(backoff_attempt == e_ratt, "R6 backoff_attempt", backoff_attempt, e_ratt);
      chk(frame_done == e_done, "R7 frame_done", frame_done, e_done);
      chk(fifo_flush == e_flush, "R8 fifo_flush", fifo_flush, e_flush);
      chk({st_one, st_more, st_fail} == {e_one, e_more, e_fail}, "R10 flags",
          {st_one, st_more, st_fail}, {e_one, e_more, e_fail});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame();
    frame_start = 1; tick(); frame_start = 0;
    // R10
    chk({st_one, st_more, st_fail} == 3'b000, "R10 cleared", {st_one, st_more, st_fail}, 0);
  endtask

  // kind: 0 clean, 1 payload collision, 2 preamble collision, 3 late collision
  task automatic attempt(input int kind, input int num, input int bo, output bit retried);
    int n;
    retried = 0;
    tx_stage = 2'b01;
    for (int i = 0; i < 4; i++) begin
      col_det = (kind == 2 && i == 1);
      tick();
    end
    col_det = 0;
    if (kind == 2) chk(jam_en == 0, "R2 held in preamble", jam_en, 0);
    tx_stage = 2'b10;
    if (kind == 2) begin
      tick();
      chk(jam_en && tx_abort, "R2 jam after preamble", {jam_en, tx_abort}, 3);
    end else if (kind == 1) begin
      for (int b = 0; b < 20; b++) begin bit_cnt = BIT_W'(b); tick(); end
      bit_cnt = 20; col_det = 1; tick(); col_det = 0;
      chk(jam_en && tx_abort, "R3 jam at once", {jam_en, tx_abort}, 3);
    end else begin
      for (int b = 0; b < 10; b++) begin bit_cnt = BIT_W'(b); tick(); end
      if (kind == 3) begin
        bit_cnt = 600; col_det = 1; tick(); col_det = 0;
        chk(jam_en == 0 && tx_abort == 0, "R5 late collision ignored", jam_en, 0);
      end
      tx_done = 1; tick(); tx_done = 0; tx_stage = 2'b00; bit_cnt = 0;
      chk(frame_done == 1, "R7 done", frame_done, 1);
      return;
    end
    tx_stage = 2'b00; bit_cnt = 0;
    n = 0;
    while (jam_en) begin n++; tick(); end
    chk(n == 32, "R4 jam length", n, 32);
    if (backoff_req) begin
      chk(backoff_attempt == num, "R6 attempt number", backoff_attempt, num);
      // R5: collision while waiting for backoff
      col_det = 1; tick(); col_det = 0;
      chk(jam_en == 0, "R5 idle collision ignored", jam_en, 0);
      tick(bo);
      backoff_done = 1; tick(); backoff_done = 0;
      retried = 1;
    end
  endtask

  task automatic frame(input int kinds[$], input int bo);
    bit r;
    start_frame();
    for (int i = 0; i < kinds.size(); i++) begin
      attempt(kinds[i], i + 1, bo, r);
      if (!r) break;
    end
  endtask

  initial begin
    int ks[$];
    tick(3);
    rst_n = 1;
    tick();
    // R1
    chk({jam_en, tx_abort, backoff_req, frame_done, fifo_flush, st_one, st_more, st_fail} == 0,
        "R1 reset state", {jam_en, tx_abort, backoff_req, frame_done}, 0);

    frame('{0}, 3);
    chk(!st_one && !st_more && !st_fail, "R7 no retry flags", {st_one, st_more, st_fail}, 0);

    frame('{1, 0}, 5);
    chk(st_one && !st_more, "R7 one retry", {st_one, st_more, st_fail}, 3'b100);

    frame('{2, 1, 0}, 1);
    chk(!st_one && st_more, "R7 more retries", {st_one, st_more, st_fail}, 3'b010);

    frame('{3}, 1);
    chk(!st_one && !st_more && !st_fail, "R5 late frame flags", {st_one, st_more, st_fail}, 0);

    ks = {};
    for (int i = 0; i < 16; i++) ks.push_back(1);
    frame(ks, 2);
    tick(-1 + 1);
    chk(st_fail && !st_one && !st_more, "R8 retries exhausted", {st_one, st_more, st_fail}, 3'b001);

    retry_dis = 1;
    frame('{1}, 2);
    retry_dis = 0;
    chk(st_fail && !st_one && !st_more, "R9 retry disabled", {st_one, st_more, st_fail}, 3'b001);

    start_frame();   // R10 flags cleared after a failure
    tick(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R8 / R9: flush strobe seen only with the failure outcome
  always @(negedge clk) begin
    if (rst_n && fifo_flush)
      chk(frame_done && st_fail && !backoff_req, "R8 R9 flush cycle", {frame_done, st_fail}, 3);
  end
endmodule